// File: doc/BRIEF.md
# Memory Activity Idle Monitor

This block measures how busy an external memory interface is over a programmed sample window. While gathering, it counts every memory clock cycle in a total counter. It also counts the cycles in which the single-bit activity input is high, and keeps that count prescaled by a power of two. Gathering stops by itself when the total reaches the programmed window limit, and a sticky flag then reports that the window has closed.

Four gather commands drive the block over a two-bit command port: reset, clear, enable and disable. A separate write port loads the window limit. Software normally clears the counters, programs the limit as the nominal interval plus half the limit accuracy (8 cycles), enables, and reads the results afterwards. The idle count output restores the prescaled active count by shifting it left by an exponent M, then subtracts it from the total. The result never goes below zero. M is 1 when the memory bus is 32 bits wide and 2 when it is 16 bits wide.

Control is a three-state machine:
- Off: stopped, readings held.
- Run: gathering.
- Full: the window limit has been reached.

Its transitions are:
- Off→Run on enable.
- Off→Full on enable when the total already meets the limit.
- Run→Full when the count reaches the limit.
- Full→Run on clear.
- Run/Full→Off on disable or reset.
- Run and Off remain where they are on clear.

Top module: `mem_idle_monitor`

## Requirements
- R1: A command is taken when `cmd_valid` is high at a rising clock edge. `cmd_code` encodes 0 = reset, 1 = clear, 2 = enable, 3 = disable.
- R2: A reset command stops gathering, zeroes both counters and the prescaler, and drops `window_done`. It does not change the window limit register.
- R3: A clear command zeroes both counters, the prescaler and `window_done`. A block that was in Run or Full is in Run afterwards. A block in Off stays in Off.
- R4: After an enable command from Off, `total_clks` increments by exactly one at every following clock edge while gathering.
- R5: Gathering ends at the edge where `total_clks` reaches the window limit. `window_done` rises at that same edge and stays high until a clear or reset. Enabling with the total already at or above the limit (for example a limit of 0) sets `window_done` at once without counting.
- R6: `active_cnt` increments once for every 2^M counted cycles that have `mem_active` high. M = 1 when `bus_narrow` = 0 and M = 2 when `bus_narrow` = 1. Cycles that are not counted are not sampled.
- R7: A disable command stops gathering and holds both readings, the prescaler phase and `window_done`. A later enable resumes from the held values.
- R8: `idle_cnt` equals `total_clks − (active_cnt << M)` when that difference is positive, and 0 otherwise.
- R9: A command has priority over counting in the same cycle, so no total or activity count is made at an edge where a command is taken.
- R10: A write with `limit_wr` high loads `limit_data` into the window limit register at that edge. Commands never change this register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Gather command: 0 reset, 1 clear, 2 enable, 3 disable |
| limit_wr | input | 1 | Window limit write strobe |
| limit_data | input | 32 | Window limit in memory clock cycles |
| bus_narrow | input | 1 | 1 = 16-bit bus (M = 2), 0 = 32-bit bus (M = 1) |
| mem_active | input | 1 | Memory access detected this cycle |
| total_clks | output | 32 | Total clock readout |
| active_cnt | output | 24 | Prescaled active count readout |
| idle_cnt | output | 32 | Scaled, saturated idle count |
| window_done | output | 1 | Sticky window-limit-reached flag |
| gathering | output | 1 | High while in Run |

## Verification
Two events can fall on the same edge: a command, and the count that would close the window. The bench provokes this by issuing a disable exactly at the edge where the total would reach the limit. It then checks that the total stays one short and that `window_done` stays low. It also issues a clear on a closed window and checks that the flag drops and counting restarts. A second overlap is a change of `bus_narrow` with the readings held: this pushes the shifted active count past the total and must produce a saturated idle count of zero.

// File: rtl/mim_pkg.sv
package mim_pkg;

    typedef enum logic [1:0] {
        CMD_RESET   = 2'd0,
        CMD_CLEAR   = 2'd1,
        CMD_ENABLE  = 2'd2,
        CMD_DISABLE = 2'd3
    } gather_cmd_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } gather_state_e;

endpackage

// File: rtl/mim_ctl.sv
module mim_ctl
    import mim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic at_limit,
    input  logic reach_next,
    output logic cnt_zero,
    output logic cnt_en,
    output logic running,
    output logic done
);

    gather_state_e state_q, state_d;
    gather_cmd_e   cmd;
    logic          done_q;

    assign cmd = gather_cmd_e'(cmd_code);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (cmd)
                CMD_RESET:   state_d = ST_OFF;
                CMD_CLEAR:   state_d = (state_q == ST_OFF) ? ST_OFF : ST_RUN;
                CMD_ENABLE:  if (state_q == ST_OFF) state_d = at_limit ? ST_FULL : ST_RUN;
                CMD_DISABLE: state_d = ST_OFF;
            endcase
        end else if (state_q == ST_RUN && reach_next) begin
            state_d = ST_FULL;
        end
    end

    // outputs
    always_comb begin
        cnt_zero = cmd_valid && (cmd == CMD_RESET || cmd == CMD_CLEAR);
        cnt_en   = !cmd_valid && (state_q == ST_RUN);
        running  = (state_q == ST_RUN);
        done     = done_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (cnt_zero)
            done_q <= 1'b0;
        else if (state_d == ST_FULL && state_q != ST_FULL)
            done_q <= 1'b1;
    end

endmodule

// File: rtl/mim_counters.sv
module mim_counters #(
    parameter int TOTAL_W  = 32,
    parameter int ACT_W    = 24,
    parameter int M_WIDE   = 1,
    parameter int M_NARROW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               zero,
    input  logic               count,
    input  logic               narrow,
    input  logic               act,
    input  logic [TOTAL_W-1:0] limit,
    output logic [TOTAL_W-1:0] total,
    output logic [ACT_W-1:0]   active,
    output logic               at_limit,
    output logic               reach_next
);

    localparam int PRE_W = (M_NARROW > M_WIDE) ? M_NARROW : M_WIDE;
    localparam logic [PRE_W-1:0] MASK_WIDE   = PRE_W'((1 << M_WIDE) - 1);
    localparam logic [PRE_W-1:0] MASK_NARROW = PRE_W'((1 << M_NARROW) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;
    logic [TOTAL_W:0] total_inc;

    assign pre_mask   = narrow ? MASK_NARROW : MASK_WIDE;
    assign total_inc  = {1'b0, total} + 1'b1;
    assign at_limit   = (total >= limit);
    assign reach_next = (total_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (zero) begin
            total <= '0;
        end else if (count && total != '1) begin
            total <= total_inc[TOTAL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            active <= '0;
        end else if (zero) begin
            pre_q  <= '0;
            active <= '0;
        end else if (count && act) begin
            if ((pre_q & pre_mask) == pre_mask) begin
                pre_q <= '0;
                if (active != '1) active <= active + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mim_scale.sv
module mim_scale #(
    parameter int TOTAL_W  = 32,
    parameter int ACT_W    = 24,
    parameter int M_WIDE   = 1,
    parameter int M_NARROW = 2
) (
    input  logic               narrow,
    input  logic [TOTAL_W-1:0] total,
    input  logic [ACT_W-1:0]   active,
    output logic [TOTAL_W-1:0] idle
);

    localparam int M_MAX = (M_NARROW > M_WIDE) ? M_NARROW : M_WIDE;
    localparam int SH_W  = ACT_W + M_MAX;
    localparam int CMP_W = (SH_W > TOTAL_W) ? SH_W : TOTAL_W;

    logic [CMP_W-1:0] shifted;
    logic [CMP_W-1:0] total_x;

    always_comb begin
        shifted = CMP_W'(active);
        shifted = narrow ? (shifted << M_NARROW) : (shifted << M_WIDE);
        total_x = CMP_W'(total);
        if (total_x > shifted) idle = TOTAL_W'(total_x - shifted);
        else                   idle = '0;
    end

endmodule

// File: rtl/mem_idle_monitor.sv
module mem_idle_monitor #(
    parameter int TOTAL_W  = 32,
    parameter int ACT_W    = 24,
    parameter int M_WIDE   = 1,
    parameter int M_NARROW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_code,
    input  logic               limit_wr,
    input  logic [TOTAL_W-1:0] limit_data,
    input  logic               bus_narrow,
    input  logic               mem_active,
    output logic [TOTAL_W-1:0] total_clks,
    output logic [ACT_W-1:0]   active_cnt,
    output logic [TOTAL_W-1:0] idle_cnt,
    output logic               window_done,
    output logic               gathering
);

    logic [TOTAL_W-1:0] limit_q;
    logic cnt_zero, cnt_en, at_limit, reach_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        limit_q <= '0;
        else if (limit_wr) limit_q <= limit_data;
    end

    mim_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .at_limit   (at_limit),
        .reach_next (reach_next),
        .cnt_zero   (cnt_zero),
        .cnt_en     (cnt_en),
        .running    (gathering),
        .done       (window_done)
    );

    mim_counters #(
        .TOTAL_W(TOTAL_W), .ACT_W(ACT_W), .M_WIDE(M_WIDE), .M_NARROW(M_NARROW)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero       (cnt_zero),
        .count      (cnt_en),
        .narrow     (bus_narrow),
        .act        (mem_active),
        .limit      (limit_q),
        .total      (total_clks),
        .active     (active_cnt),
        .at_limit   (at_limit),
        .reach_next (reach_next)
    );

    mim_scale #(
        .TOTAL_W(TOTAL_W), .ACT_W(ACT_W), .M_WIDE(M_WIDE), .M_NARROW(M_NARROW)
    ) u_scale (
        .narrow (bus_narrow),
        .total  (total_clks),
        .active (active_cnt),
        .idle   (idle_cnt)
    );

endmodule

// File: rtl/mim_checker.sv
module mim_checker #(
    parameter int TOTAL_W = 32,
    parameter int ACT_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_code,
    input logic [TOTAL_W-1:0] total_clks,
    input logic [ACT_W-1:0]   active_cnt,
    input logic [TOTAL_W-1:0] idle_cnt,
    input logic               window_done,
    input logic               gathering
);

    assert_reset_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'd0) |=>
            (!gathering && total_clks == '0 && active_cnt == '0 && !window_done));

    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'd1) |=>
            (total_clks == '0 && active_cnt == '0 && !window_done));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gathering && !cmd_valid) |=> (total_clks == $past(total_clks) + 1'b1));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (window_done && !(cmd_valid && cmd_code[1] == 1'b0)) |=> window_done);

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gathering && !cmd_valid) |=> ($stable(total_clks) && $stable(active_cnt)));

    assert_idle_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= total_clks);

    assert_command_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'd3) |=>
            (!gathering && $stable(total_clks) && $stable(active_cnt)));

endmodule

bind mem_idle_monitor mim_checker #(.TOTAL_W(TOTAL_W), .ACT_W(ACT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .total_clks  (total_clks),
    .active_cnt  (active_cnt),
    .idle_cnt    (idle_cnt),
    .window_done (window_done),
    .gathering   (gathering)
);

// File: tb/sim_mem_idle_monitor.sv
`timescale 1ns/1ps
module sim_mem_idle_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_code = 2'd0;
    logic        limit_wr = 1'b0;
    logic [31:0] limit_data = '0;
    logic        bus_narrow = 1'b0;
    logic        mem_active = 1'b0;
    logic [31:0] total_clks;
    logic [23:0] active_cnt;
    logic [31:0] idle_cnt;
    logic        window_done;
    logic        gathering;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mem_idle_monitor u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .limit_wr(limit_wr), .limit_data(limit_data), .bus_narrow(bus_narrow),
        .mem_active(mem_active), .total_clks(total_clks), .active_cnt(active_cnt),
        .idle_cnt(idle_cnt), .window_done(window_done), .gathering(gathering)
    );

    localparam logic [1:0] C_RESET = 2'd0, C_CLEAR = 2'd1, C_EN = 2'd2, C_DIS = 2'd3;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] idle_of(logic [31:0] t, logic [23:0] a, bit n);
        longint s;
        s = longint'(a) << (n ? 2 : 1);
        return (longint'(t) > s) ? 32'(longint'(t) - s) : 32'd0;
    endfunction

    task automatic issue(logic [1:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_limit(logic [31:0] v);
        limit_wr = 1'b1; limit_data = v;
        @(negedge clk);
        limit_wr = 1'b0;
    endtask

    task automatic run(int n, logic a);
        for (int i = 0; i < n; i++) begin
            mem_active = a;
            @(negedge clk);
        end
        mem_active = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R2", "total after reset", total_clks, 0);
        chk("R2", "active after reset", 32'(active_cnt), 0);
        chk("R2", "done after reset", 32'(window_done), 0);
        chk("R2", "gathering after reset", 32'(gathering), 0);
    endtask

    task automatic t_full_window;
        bus_narrow = 1'b0;
        set_limit(10); issue(C_CLEAR); issue(C_EN);
        chk("R4", "total right after enable", total_clks, 0);
        chk("R1", "gathering after enable", 32'(gathering), 1);
        run(10, 1'b1);
        chk("R5", "total at limit", total_clks, 10);
        chk("R6", "active wide all busy", 32'(active_cnt), 5);
        chk("R5", "done at limit", 32'(window_done), 1);
        chk("R8", "idle all busy", idle_cnt, 0);
        run(3, 1'b1);
        chk("R5", "total frozen after limit", total_clks, 10);
        chk("R5", "done sticky", 32'(window_done), 1);
    endtask

    task automatic t_partial_wide;
        issue(C_CLEAR);
        chk("R3", "clear from full resumes", 32'(gathering), 1);
        chk("R3", "done cleared", 32'(window_done), 0);
        run(4, 1'b1); run(6, 1'b0);
        chk("R6", "active wide partial", 32'(active_cnt), 2);
        chk("R8", "idle wide partial", idle_cnt, idle_of(10, 2, 1'b0));
    endtask

    task automatic t_narrow;
        bus_narrow = 1'b1;
        set_limit(20); issue(C_CLEAR);
        run(11, 1'b1); run(9, 1'b0);
        chk("R6", "active narrow", 32'(active_cnt), 2);
        chk("R8", "idle narrow", idle_cnt, 12);
        chk("R5", "narrow done", 32'(window_done), 1);
        bus_narrow = 1'b0;
    endtask

    task automatic t_disable_resume;
        set_limit(100); issue(C_CLEAR);
        run(7, 1'b1);
        issue(C_DIS);
        run(5, 1'b1);
        chk("R7", "total held", total_clks, 7);
        chk("R7", "active held", 32'(active_cnt), 3);
        chk("R7", "stopped", 32'(gathering), 0);
        chk("R8", "idle while held", idle_cnt, 1);
        issue(C_EN);
        run(3, 1'b1);
        chk("R7", "total resumes", total_clks, 10);
        chk("R7", "prescaler phase kept", 32'(active_cnt), 5);
    endtask

    task automatic t_clear_running;
        issue(C_CLEAR);
        chk("R3", "total zero", total_clks, 0);
        chk("R3", "active zero", 32'(active_cnt), 0);
        chk("R3", "still gathering", 32'(gathering), 1);
        run(4, 1'b0);
        chk("R8", "idle no activity", idle_cnt, 4);
    endtask

    task automatic t_reset_cmd;
        run(2, 1'b1);
        issue(C_RESET);
        chk("R2", "cmd reset stops", 32'(gathering), 0);
        chk("R2", "cmd reset zero", total_clks, 0);
        issue(C_EN);
        run(100, 1'b0);
        chk("R10", "limit kept across reset", total_clks, 100);
        chk("R10", "done at kept limit", 32'(window_done), 1);
    endtask

    task automatic t_limit_zero;
        issue(C_DIS);
        set_limit(0); issue(C_RESET); issue(C_EN);
        chk("R5", "zero limit done", 32'(window_done), 1);
        chk("R5", "zero limit not gathering", 32'(gathering), 0);
        run(3, 1'b1);
        chk("R5", "zero limit no count", total_clks, 0);
        issue(C_DIS);
        chk("R7", "done kept over disable", 32'(window_done), 1);
    endtask

    task automatic t_collision;
        set_limit(5); issue(C_RESET); issue(C_EN);
        run(4, 1'b1);
        mem_active = 1'b1;
        issue(C_DIS);
        mem_active = 1'b0;
        chk("R9", "disable wins over last count", total_clks, 4);
        chk("R9", "no done on collision", 32'(window_done), 0);
        chk("R9", "no activity counted", 32'(active_cnt), 2);
        issue(C_EN);
        run(1, 1'b0);
        chk("R5", "closes after resume", total_clks, 5);
        chk("R5", "done after resume", 32'(window_done), 1);
    endtask

    task automatic t_saturate;
        set_limit(8); issue(C_RESET); bus_narrow = 1'b0; issue(C_EN);
        run(8, 1'b1);
        chk("R8", "idle equal case", idle_cnt, 0);
        bus_narrow = 1'b1;
        #1;
        chk("R8", "idle saturates when shifted exceeds total", idle_cnt, 0);
        bus_narrow = 1'b0;
        issue(C_CLEAR);
        run(3, 1'b1);
        chk("R8", "idle odd", idle_cnt, idle_of(3, 1, 1'b0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_full_window;
        t_partial_wide;
        t_narrow;
        t_disable_resume;
        t_clear_running;
        t_reset_cmd;
        t_limit_zero;
        t_collision;
        t_saturate;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule